// File: doc/BRIEF.md
# Breakpoint Loop Halt Controller

This block decides when a small 8-bit CPU stops for a debugger. It watches every valid instruction fetch for the breakpoint opcode, which is 00H, the same value as a fully programmed flash byte. When the break-loop control bit is clear, a fetched breakpoint halts the core and the block enters debug mode on the next clock. When the break-loop bit is set, the core instead keeps re-executing the breakpoint and stays able to take interrupts. An idle status flag shows the host that the core is waiting in that loop.

To stop a core that is waiting in the loop, the host clears the break-loop bit and does not set the debug-mode bit itself. The block counts how deeply interrupt handlers are nested since the loop began. It moves to debug mode only when the core is back on the breakpoint: either the last handler returns, or the breakpoint is fetched again with no handler active. It also decides whether each debugger command class is allowed, based on the current mode and a read-protect option. A host write that clears the debug-mode bit releases the core.

Top module: `bkpt_halt_ctrl`

## Requirements
- R1: After reset the block is in run mode: `halt`, `stat_dbg`, `stat_idle` and `ctrl_loop_en` are 0, and `loop_hold` and `irq_allow` are 1 only once the loop is entered or in run mode respectively (`irq_allow`=1, `loop_hold`=0).
- R2: In run mode, a valid fetch of opcode 00H with the break-loop bit clear sets `halt` and `stat_dbg` to 1 on the next clock.
- R3: In run mode, a valid fetch of opcode 00H with the break-loop bit set makes `stat_idle` and `loop_hold` 1 on the next clock, while `halt` stays 0.
- R4: A fetch whose opcode is not 00H, or any opcode presented while `fetch_vld` is 0, leaves the mode unchanged.
- R5: While looping, each `irq_enter` pulse raises the nesting depth and `loop_hold` is 0 whenever the depth is non-zero. `irq_allow` is 1 in run and loop modes and 0 in debug mode.
- R6: If the break-loop bit is cleared while a handler is active, the block stays in the loop until an `irq_ret` pulse takes the depth from 1 to 0; `halt` and `stat_dbg` rise on the next clock after that pulse.
- R7: If the break-loop bit is cleared while no handler is active, the block enters debug mode on the clock after the next valid fetch of 00H.
- R8: An `irq_ret` at depth 0 does not change the depth, and the depth saturates at 2^DEPTH_W-1 (7 with defaults) instead of wrapping.
- R9: A host write with bit 1 of `host_wdata` at 0 in debug mode returns the block to run mode, so `halt` drops on the next clock. A write with bit 1 at 1 never changes the mode.
- R10: Outside debug mode, `cmd_ok` is 1 only for command class 2'b00 (normal-mode commands).
- R11: In debug mode, `cmd_ok` is 1 for classes 2'b00 and 2'b01 (debug-only), 1 for class 2'b10 (protect-sensitive) only when `rd_protect` is 0, and always 0 for class 2'b11.
- R12: `ctrl_loop_en` shows bit 0 of the most recent host write, from the next clock onwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fetch_vld | input | 1 | An opcode is being fetched this cycle |
| fetch_op | input | 8 | Fetched opcode |
| irq_enter | input | 1 | Core vectored into an interrupt handler this cycle |
| irq_ret | input | 1 | Core executed a return from interrupt this cycle |
| host_wr | input | 1 | Host writes the control bits this cycle |
| host_wdata | input | 2 | Bit 0: break-loop enable; bit 1: debug-mode bit |
| rd_protect | input | 1 | Read-protect option is programmed |
| cmd_class | input | 2 | Class of the command being checked |
| halt | output | 1 | Core is stopped in debug mode |
| loop_hold | output | 1 | Core re-executes the breakpoint (loop, no handler active) |
| irq_allow | output | 1 | Interrupts may be taken |
| stat_idle | output | 1 | Status: looping on a breakpoint |
| stat_dbg | output | 1 | Status: debug-mode bit |
| ctrl_loop_en | output | 1 | Readback of the break-loop bit |
| cmd_ok | output | 1 | The presented command class is allowed now |

## Verification
The hardest situation to reach is the release of a loop while handlers are nested. The break-loop bit has to be cleared between an interrupt entry and the matching return, and the change to debug mode must happen only on the final return. The bench enters the loop, pulses `irq_enter` twice, and clears the bit through a host write. It then checks that the first return leaves the core looping and that the second one halts it. A separate scenario drives eight handler entries and seven returns, so that a wrapped counter would show up as `loop_hold` at the wrong time.

// File: rtl/bkpt_pkg.sv
// Package: shared types and encodings for the breakpoint halt controller.
// Assumes: a two-bit command class and a two-bit host control word.
package bkpt_pkg;

    // Operating mode of the controller.
    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_LOOP  = 2'd1,
        ST_DEBUG = 2'd2
    } bk_state_e;

    // Command class encodings seen on cmd_class.
    localparam logic [1:0] CMD_NORMAL = 2'd0;
    localparam logic [1:0] CMD_DBG    = 2'd1;
    localparam logic [1:0] CMD_PROT   = 2'd2;

    // Bit positions in the host control word.
    localparam int CTRL_LOOP_BIT = 0;
    localparam int CTRL_DBG_BIT  = 1;
    localparam int CTRL_W        = 2;

endpackage

// File: rtl/bkpt_ctrl_regs.sv
// Module: host-writable break-loop enable bit.
// Assumes: host_wr is a single-cycle strobe; the bit reads back from the next clock.
module bkpt_ctrl_regs (
    input  logic clk,
    input  logic rst_n,
    input  logic host_wr,
    input  logic host_loop_bit,
    output logic loop_en
);

    // Capture the break-loop bit on every host write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            loop_en <= 1'b0;
        end else if (host_wr) begin
            loop_en <= host_loop_bit;
        end
    end

    // R12: readback equals the bit written one clock earlier.
    a_r12_readback: assert property (@(posedge clk) disable iff (!rst_n)
        host_wr |=> (loop_en == $past(host_loop_bit)));

endmodule

// File: rtl/bkpt_irq_depth.sv
// Module: saturating interrupt nesting counter, live only while looping.
// Assumes: inc/dec are single-cycle strobes; the count clears whenever inactive.
module bkpt_irq_depth #(
    parameter int DEPTH_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               active,
    input  logic               inc,
    input  logic               dec,
    output logic [DEPTH_W-1:0] depth,
    output logic               is_zero,
    output logic               is_one
);

    localparam logic [DEPTH_W-1:0] D_MAX = '1;
    localparam logic [DEPTH_W-1:0] D_ONE = DEPTH_W'(1);

    // Track nesting depth, clamped at both ends.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            depth <= '0;
        end else begin
            case ({inc, dec})
                2'b10:   if (depth != D_MAX) depth <= depth + D_ONE;
                2'b01:   if (depth != '0)    depth <= depth - D_ONE;
                default: depth <= depth;
            endcase
        end
    end

    // Decode the two depths the state machine needs.
    always_comb begin
        is_zero = (depth == '0);
        is_one  = (depth == D_ONE);
    end

    // R8: a return at depth zero leaves the count at zero.
    a_r8_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        (active && is_zero && dec && !inc) |=> is_zero);

    // R8: entering at full depth does not wrap.
    a_r8_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        (active && (depth == D_MAX) && inc && !dec) |=> (depth == D_MAX));

endmodule

// File: rtl/bkpt_mode_fsm.sv
// Module: mode state machine (run / breakpoint loop / debug).
// Assumes: the mode moves only on a valid fetch, a handler return, or a host
// write that clears the debug-mode bit; depth flags come from the counter.
module bkpt_mode_fsm
    import bkpt_pkg::*;
#(
    parameter int              OPC_W   = 8,
    parameter logic [OPC_W-1:0] BRK_OPC = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fetch_vld,
    input  logic [OPC_W-1:0] fetch_op,
    input  logic             irq_enter,
    input  logic             irq_ret,
    input  logic             loop_en,
    input  logic             host_wr,
    input  logic             host_dbg_bit,
    input  logic             depth_zero,
    input  logic             depth_one,
    output bk_state_e        state
);

    bk_state_e state_nxt;
    logic      brk_seen;
    logic      last_ret;
    logic      host_release;

    // Decode events that can move the mode.
    always_comb begin
        brk_seen     = fetch_vld && (fetch_op == BRK_OPC);
        last_ret     = irq_ret && !irq_enter && depth_one;
        host_release = host_wr && !host_dbg_bit;
    end

    // Next-mode selection.
    always_comb begin
        state_nxt = state;
        case (state)
            ST_RUN: begin
                if (brk_seen) state_nxt = loop_en ? ST_LOOP : ST_DEBUG;
            end
            ST_LOOP: begin
                if (!loop_en && (last_ret || (brk_seen && depth_zero)))
                    state_nxt = ST_DEBUG;
            end
            ST_DEBUG: begin
                if (host_release) state_nxt = ST_RUN;
            end
            default: state_nxt = ST_RUN;
        endcase
    end

    // Mode register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= state_nxt;
    end

    // R2: breakpoint with the loop bit clear halts on the next clock.
    a_r2_direct_halt: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && fetch_vld && fetch_op == BRK_OPC && !loop_en)
        |=> (state == ST_DEBUG));

    // R3: breakpoint with the loop bit set enters the loop.
    a_r3_enter_loop: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && fetch_vld && fetch_op == BRK_OPC && loop_en)
        |=> (state == ST_LOOP));

    // R4: in run mode, anything but a valid breakpoint keeps run mode.
    a_r4_run_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && !(fetch_vld && fetch_op == BRK_OPC))
        |=> (state == ST_RUN));

    // R6: with a handler active and no return, the loop persists.
    a_r6_wait_handler: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOOP && !depth_zero && !irq_ret) |=> (state == ST_LOOP));

    // R9: clearing the debug-mode bit in debug returns to run.
    a_r9_release: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DEBUG && host_wr && !host_dbg_bit) |=> (state == ST_RUN));

    // R9: debug is only left through a host release.
    a_r9_debug_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DEBUG && !(host_wr && !host_dbg_bit)) |=> (state == ST_DEBUG));

endmodule

// File: rtl/bkpt_cmd_gate.sv
// Module: combinational command-class permission check.
// Assumes: cmd_class and rd_protect are stable when cmd_ok is sampled.
module bkpt_cmd_gate
    import bkpt_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  bk_state_e state,
    input  logic      rd_protect,
    input  logic [1:0] cmd_class,
    output logic      cmd_ok
);

    logic in_debug;

    // Decide permission from the mode, the class and read protection.
    always_comb begin
        in_debug = (state == ST_DEBUG);
        if (!in_debug) begin
            cmd_ok = (cmd_class == CMD_NORMAL);
        end else begin
            case (cmd_class)
                CMD_NORMAL: cmd_ok = 1'b1;
                CMD_DBG:    cmd_ok = 1'b1;
                CMD_PROT:   cmd_ok = !rd_protect;
                default:    cmd_ok = 1'b0;
            endcase
        end
    end

    // R10: outside debug only normal-mode commands pass.
    a_r10_run_subset: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_debug && cmd_ok) |-> (cmd_class == CMD_NORMAL));

    // R11: read protection blocks the protect-sensitive class.
    a_r11_protect: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_protect && cmd_class == CMD_PROT) |-> !cmd_ok);

endmodule

// File: rtl/bkpt_halt_ctrl.sv
// Module: top of the breakpoint halt controller.
// Assumes: fetch, interrupt and host strobes are synchronous to clk and
// last one cycle each; the breakpoint opcode is 00H by default.
module bkpt_halt_ctrl
    import bkpt_pkg::*;
#(
    parameter int              OPC_W   = 8,
    parameter logic [OPC_W-1:0] BRK_OPC = '0,
    parameter int              DEPTH_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_vld,
    input  logic [OPC_W-1:0]  fetch_op,
    input  logic              irq_enter,
    input  logic              irq_ret,
    input  logic              host_wr,
    input  logic [CTRL_W-1:0] host_wdata,
    input  logic              rd_protect,
    input  logic [1:0]        cmd_class,
    output logic              halt,
    output logic              loop_hold,
    output logic              irq_allow,
    output logic              stat_idle,
    output logic              stat_dbg,
    output logic              ctrl_loop_en,
    output logic              cmd_ok
);

    bk_state_e          state;
    logic               loop_en;
    logic [DEPTH_W-1:0] depth;
    logic               depth_zero;
    logic               depth_one;
    logic               in_loop;

    bkpt_ctrl_regs u_regs (
        .clk           (clk),
        .rst_n         (rst_n),
        .host_wr       (host_wr),
        .host_loop_bit (host_wdata[CTRL_LOOP_BIT]),
        .loop_en       (loop_en)
    );

    bkpt_irq_depth #(.DEPTH_W(DEPTH_W)) u_depth (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (in_loop),
        .inc     (irq_enter),
        .dec     (irq_ret),
        .depth   (depth),
        .is_zero (depth_zero),
        .is_one  (depth_one)
    );

    bkpt_mode_fsm #(.OPC_W(OPC_W), .BRK_OPC(BRK_OPC)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .fetch_vld    (fetch_vld),
        .fetch_op     (fetch_op),
        .irq_enter    (irq_enter),
        .irq_ret      (irq_ret),
        .loop_en      (loop_en),
        .host_wr      (host_wr),
        .host_dbg_bit (host_wdata[CTRL_DBG_BIT]),
        .depth_zero   (depth_zero),
        .depth_one    (depth_one),
        .state        (state)
    );

    bkpt_cmd_gate u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .state      (state),
        .rd_protect (rd_protect),
        .cmd_class  (cmd_class),
        .cmd_ok     (cmd_ok)
    );

    // Drive the core controls and status flags from the mode.
    always_comb begin
        in_loop      = (state == ST_LOOP);
        halt         = (state == ST_DEBUG);
        stat_dbg     = (state == ST_DEBUG);
        stat_idle    = in_loop;
        loop_hold    = in_loop && depth_zero;
        irq_allow    = (state != ST_DEBUG);
        ctrl_loop_en = loop_en;
    end

    // R5: the core is never held on the breakpoint while a handler runs.
    a_r5_handler_free: assert property (@(posedge clk) disable iff (!rst_n)
        (in_loop && irq_enter && !irq_ret) |=> !loop_hold);

    // R5: a halted core takes no interrupts.
    a_r5_no_irq_halted: assert property (@(posedge clk) disable iff (!rst_n)
        halt |-> !irq_allow);

    // R1: halt and idle never assert together.
    a_r1_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(halt && stat_idle));

endmodule

// File: tb/bkpt_halt_ctrl_bench.sv
module bkpt_halt_ctrl_bench;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       fetch_vld;
    logic [7:0] fetch_op;
    logic       irq_enter;
    logic       irq_ret;
    logic       host_wr;
    logic [1:0] host_wdata;
    logic       rd_protect;
    logic [1:0] cmd_class;
    logic       halt, loop_hold, irq_allow, stat_idle, stat_dbg, ctrl_loop_en, cmd_ok;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    bkpt_halt_ctrl u_bkpt_halt_ctrl (
        .clk(clk), .rst_n(rst_n), .fetch_vld(fetch_vld), .fetch_op(fetch_op),
        .irq_enter(irq_enter), .irq_ret(irq_ret), .host_wr(host_wr),
        .host_wdata(host_wdata), .rd_protect(rd_protect), .cmd_class(cmd_class),
        .halt(halt), .loop_hold(loop_hold), .irq_allow(irq_allow),
        .stat_idle(stat_idle), .stat_dbg(stat_dbg), .ctrl_loop_en(ctrl_loop_en),
        .cmd_ok(cmd_ok)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0b expected=%0b", req, what, act, exp);
        end
    endtask

    // Check halt / idle / hold together.
    task automatic chk_mode(input string req, input logic e_halt, input logic e_idle, input logic e_hold);
        chk(req, "halt", halt, e_halt);
        chk(req, "stat_dbg", stat_dbg, e_halt);
        chk(req, "stat_idle", stat_idle, e_idle);
        chk(req, "loop_hold", loop_hold, e_hold);
    endtask

    // One-cycle stimulus helpers: drive at negedge, release at next negedge.
    task automatic fetch(input logic vld, input logic [7:0] op);
        fetch_vld = vld; fetch_op = op;
        @(negedge clk);
        fetch_vld = 1'b0; fetch_op = 8'hFF;
    endtask

    task automatic irq_in();
        irq_enter = 1'b1;
        @(negedge clk);
        irq_enter = 1'b0;
    endtask

    task automatic irq_out();
        irq_ret = 1'b1;
        @(negedge clk);
        irq_ret = 1'b0;
    endtask

    task automatic hwrite(input logic loop_bit, input logic dbg_bit);
        host_wr = 1'b1; host_wdata = {dbg_bit, loop_bit};
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic gate(input string req, input logic [1:0] cls, input logic rp, input logic exp);
        cmd_class = cls; rd_protect = rp;
        #1;
        chk(req, $sformatf("cmd_ok class=%0d rp=%0b", cls, rp), cmd_ok, exp);
        cmd_class = 2'd0; rd_protect = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        fetch_vld = 0; fetch_op = 8'hFF; irq_enter = 0; irq_ret = 0;
        host_wr = 0; host_wdata = 0; rd_protect = 0; cmd_class = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk_mode("R1", 1'b0, 1'b0, 1'b0);
        chk("R1", "ctrl_loop_en", ctrl_loop_en, 1'b0);
        chk("R1", "irq_allow", irq_allow, 1'b1);
    endtask

    task automatic t_direct_halt();
        fetch(1'b1, 8'h3C);
        chk_mode("R4", 1'b0, 1'b0, 1'b0);
        fetch(1'b0, 8'h00);
        chk_mode("R4", 1'b0, 1'b0, 1'b0);
        fetch(1'b1, 8'h00);
        chk_mode("R2", 1'b1, 1'b0, 1'b0);
        chk("R5", "irq_allow in debug", irq_allow, 1'b0);
        gate("R11", 2'd0, 1'b1, 1'b1);
        gate("R11", 2'd1, 1'b1, 1'b1);
        gate("R11", 2'd2, 1'b0, 1'b1);
        gate("R11", 2'd2, 1'b1, 1'b0);
        gate("R11", 2'd3, 1'b0, 1'b0);
        hwrite(1'b0, 1'b1);
        chk_mode("R9", 1'b1, 1'b0, 1'b0);
        hwrite(1'b0, 1'b0);
        chk_mode("R9", 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_gate_run();
        gate("R10", 2'd0, 1'b0, 1'b1);
        gate("R10", 2'd1, 1'b0, 1'b0);
        gate("R10", 2'd2, 1'b0, 1'b0);
        gate("R10", 2'd3, 1'b0, 1'b0);
    endtask

    task automatic t_loop_entry();
        hwrite(1'b1, 1'b0);
        chk("R12", "ctrl_loop_en set", ctrl_loop_en, 1'b1);
        hwrite(1'b1, 1'b1);
        chk_mode("R9", 1'b0, 1'b0, 1'b0);
        fetch(1'b1, 8'h00);
        chk_mode("R3", 1'b0, 1'b1, 1'b1);
        chk("R5", "irq_allow in loop", irq_allow, 1'b1);
        fetch(1'b1, 8'h00);
        chk_mode("R3", 1'b0, 1'b1, 1'b1);
        gate("R10", 2'd1, 1'b0, 1'b0);
        gate("R10", 2'd0, 1'b0, 1'b1);
    endtask

    task automatic t_handler_release();
        irq_in();
        chk_mode("R5", 1'b0, 1'b1, 1'b0);
        irq_in();
        fetch(1'b1, 8'h00);
        hwrite(1'b0, 1'b0);
        chk("R12", "ctrl_loop_en clear", ctrl_loop_en, 1'b0);
        chk_mode("R6", 1'b0, 1'b1, 1'b0);
        fetch(1'b1, 8'h00);
        chk_mode("R6", 1'b0, 1'b1, 1'b0);
        irq_out();
        chk_mode("R6", 1'b0, 1'b1, 1'b0);
        irq_out();
        chk_mode("R6", 1'b1, 1'b0, 1'b0);
        hwrite(1'b0, 1'b0);
        chk_mode("R9", 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_clear_at_zero();
        hwrite(1'b1, 1'b0);
        fetch(1'b1, 8'h00);
        chk_mode("R7", 1'b0, 1'b1, 1'b1);
        hwrite(1'b0, 1'b0);
        chk_mode("R7", 1'b0, 1'b1, 1'b1);
        fetch(1'b1, 8'h12);
        chk_mode("R7", 1'b0, 1'b1, 1'b1);
        fetch(1'b1, 8'h00);
        chk_mode("R7", 1'b1, 1'b0, 1'b0);
        hwrite(1'b0, 1'b0);
    endtask

    task automatic t_depth_edges();
        hwrite(1'b1, 1'b0);
        fetch(1'b1, 8'h00);
        irq_out();
        chk_mode("R8", 1'b0, 1'b1, 1'b1);
        irq_in();
        chk_mode("R8", 1'b0, 1'b1, 1'b0);
        irq_out();
        chk_mode("R8", 1'b0, 1'b1, 1'b1);
        for (int i = 0; i < 8; i++) irq_in();
        chk_mode("R8", 1'b0, 1'b1, 1'b0);
        for (int i = 0; i < 6; i++) irq_out();
        chk_mode("R8", 1'b0, 1'b1, 1'b0);
        irq_out();
        chk_mode("R8", 1'b0, 1'b1, 1'b1);
        hwrite(1'b0, 1'b0);
        fetch(1'b1, 8'h00);
        chk_mode("R7", 1'b1, 1'b0, 1'b0);
        hwrite(1'b0, 1'b0);
        chk_mode("R9", 1'b0, 1'b0, 1'b0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_gate_run();
        t_direct_halt();
        t_loop_entry();
        t_handler_release();
        t_clear_at_zero();
        t_depth_edges();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule